// File: doc/BRIEF.md
# Vector Element Step Sequencer

This block holds the loop state that carries one vectorised instruction across its elements. It keeps three counters: a source element step, a destination element step and a sub-element step nested inside them. Each advance strobe moves the sequence on by one issued slot. When predicate zeroing is disabled, the source and destination steps skip past elements whose mask bit is clear. When zeroing is enabled, every element is visited and a per-side zero flag marks the elements whose mask bit is clear.

The block also produces a flattened slot offset for each side. The offset is the element step times the sub-vector size, plus the sub-step, and it can be mirrored for reverse-order traversal. A start strobe begins a new instruction. A done flag rises once the sequence has run out of elements, so the issue logic knows when to move to the next instruction. The vector length, sub-vector field, masks and mode flags are held stable by the user while a sequence is active.

Top module: `vec_step_seq`

## Requirements
- R1: After reset the source, destination and sub steps read 0, both zero flags read 0 and done reads 1 (idle).
- R2: A start strobe loads each step with its first eligible element at or above 0, clears the sub-step and clears done on the next cycle; start wins over a simultaneous advance.
- R3: A start with vector length 0, or with no eligible element on either side below the vector length, sets done on the next cycle and issues no element.
- R4: The sub-vector field encodes 1 to 4 sub-elements as values 0 to 3; an advance while the sub-step differs from that field increments only the sub-step, leaving both element steps unchanged.
- R5: An advance while the sub-step equals the sub-vector field clears the sub-step and moves each element step to the next eligible element above its current value.
- R6: With zeroing off on a side, element i is eligible only if bit i of that side's 64-bit mask is 1 (elements 64 and above are never eligible), and a step never rests on an ineligible element.
- R7: With zeroing on for a side, every element below the vector length is visited in order, and that side's zero flag is 1 exactly when the current element's mask bit is 0 (and done is 0); with zeroing off the flag stays 0.
- R8: An advance at the end of a sub-element group where either side has no further eligible element below the vector length sets done on the next cycle with all steps held; while done is 1, advances change nothing.
- R9: Each side's offset equals its element step times (sub-vector field + 1) plus the sub-step, modulo 128.
- R10: With the reverse flag set, each offset becomes (vector length times (sub-vector field + 1)) minus 1 minus the forward offset, all modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new instruction sequence |
| advance_i | input | 1 | One slot has issued; step on |
| vl_i | input | 7 | Vector length in elements |
| subvl_i | input | 2 | Sub-vector field (size minus 1) |
| src_mask_i | input | 64 | Source predicate mask, bit i for element i |
| dst_mask_i | input | 64 | Destination predicate mask, bit i for element i |
| src_zero_en_i | input | 1 | Source zeroing mode enable |
| dst_zero_en_i | input | 1 | Destination zeroing mode enable |
| reverse_i | input | 1 | Mirror the offsets |
| src_step_o | output | 7 | Current source element step |
| dst_step_o | output | 7 | Current destination element step |
| sub_step_o | output | 2 | Current sub-element step |
| src_zero_o | output | 1 | Current source element must read as zero |
| dst_zero_o | output | 1 | Current destination element must be written as zero |
| src_offset_o | output | 7 | Flattened source slot offset |
| dst_offset_o | output | 7 | Flattened destination slot offset |
| done_o | output | 1 | Sequence finished or idle |

## Verification
Full masks with a two-wide sub-vector show the sub-step nesting and the offset arithmetic apart from any skipping. Sparse source masks against a full destination mask separate the skip path on one side from plain stepping on the other. A destination mask that runs out first shows that either side can end the loop. Zeroing with alternating masks shows that elements are visited rather than skipped. Reverse runs, including one whose slot total wraps the 7-bit width, tell the mirror apart from the forward offset. A start issued mid-sequence together with an advance shows the priority between the two.

// File: rtl/vstep_pkg.sv
`timescale 1ns/1ps
package vstep_pkg;
    localparam int STEP_W = 7;
    localparam int SUB_W  = 2;
    localparam int MASK_W = 64;
    localparam int NELEM  = 1 << STEP_W;
    localparam int NSIDE  = 2;
    localparam int SIDE_SRC = 0;
    localparam int SIDE_DST = 1;

    typedef struct packed {
        logic [STEP_W-1:0] src;
        logic [STEP_W-1:0] dst;
        logic [SUB_W-1:0]  sub;
        logic              done;
    } seq_state_t;
endpackage

// File: rtl/vstep_skip.sv
`timescale 1ns/1ps
module vstep_skip #(
    parameter int STEP_W = 7,
    parameter int MASK_W = 64
) (
    input  logic [STEP_W-1:0] from_i,
    input  logic [STEP_W-1:0] vl_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              zero_en_i,
    output logic [STEP_W-1:0] next_o
);
    localparam int NELEM = 1 << STEP_W;

    logic [NELEM-1:0] elig;

    for (genvar gi = 0; gi < NELEM; gi++) begin : g_elig
        if (gi < MASK_W) begin : g_in
            assign elig[gi] = zero_en_i | mask_i[gi];
        end else begin : g_out
            assign elig[gi] = zero_en_i;
        end
    end

    always_comb begin
        next_o = vl_i;
        for (int i = NELEM - 1; i >= 0; i--) begin
            if (elig[i] && ((STEP_W+1)'(i) >= {1'b0, from_i}) &&
                ((STEP_W+1)'(i) < {1'b0, vl_i})) begin
                next_o = STEP_W'(i);
            end
        end
    end
endmodule

// File: rtl/vstep_offset.sv
`timescale 1ns/1ps
module vstep_offset #(
    parameter int STEP_W = 7,
    parameter int SUB_W  = 2
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [SUB_W-1:0]  sub_i,
    input  logic [SUB_W-1:0]  subvl_i,
    input  logic [STEP_W-1:0] vl_i,
    input  logic              reverse_i,
    output logic [STEP_W-1:0] offset_o
);
    localparam int PROD_W = STEP_W + SUB_W + 1;

    logic [SUB_W:0]      mult;
    logic [PROD_W-1:0]   scaled;
    logic [PROD_W-1:0]   total;
    logic [STEP_W-1:0]   fwd;
    logic [STEP_W-1:0]   vmax;

    always_comb begin
        mult     = {1'b0, subvl_i} + 1'b1;
        scaled   = PROD_W'(step_i) * PROD_W'(mult);
        total    = PROD_W'(vl_i) * PROD_W'(mult);
        fwd      = STEP_W'(scaled + PROD_W'(sub_i));
        vmax     = STEP_W'(total);
        offset_o = reverse_i ? (vmax - STEP_W'(1) - fwd) : fwd;
    end
endmodule

// File: rtl/vec_step_seq.sv
`timescale 1ns/1ps
module vec_step_seq
    import vstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              advance_i,
    input  logic [STEP_W-1:0] vl_i,
    input  logic [SUB_W-1:0]  subvl_i,
    input  logic [MASK_W-1:0] src_mask_i,
    input  logic [MASK_W-1:0] dst_mask_i,
    input  logic              src_zero_en_i,
    input  logic              dst_zero_en_i,
    input  logic              reverse_i,
    output logic [STEP_W-1:0] src_step_o,
    output logic [STEP_W-1:0] dst_step_o,
    output logic [SUB_W-1:0]  sub_step_o,
    output logic              src_zero_o,
    output logic              dst_zero_o,
    output logic [STEP_W-1:0] src_offset_o,
    output logic [STEP_W-1:0] dst_offset_o,
    output logic              done_o
);
    seq_state_t state_q, state_d;

    logic [STEP_W-1:0] cur_step  [NSIDE];
    logic [STEP_W-1:0] from_step [NSIDE];
    logic [STEP_W-1:0] next_step [NSIDE];
    logic [MASK_W-1:0] side_mask [NSIDE];
    logic              side_zen  [NSIDE];
    logic [STEP_W-1:0] side_off  [NSIDE];
    logic              side_zflag[NSIDE];

    assign cur_step[SIDE_SRC]  = state_q.src;
    assign cur_step[SIDE_DST]  = state_q.dst;
    assign side_mask[SIDE_SRC] = src_mask_i;
    assign side_mask[SIDE_DST] = dst_mask_i;
    assign side_zen[SIDE_SRC]  = src_zero_en_i;
    assign side_zen[SIDE_DST]  = dst_zero_en_i;

    for (genvar gs = 0; gs < NSIDE; gs++) begin : g_side
        logic [MASK_W-1:0] sel_bit;

        assign from_step[gs] = start_i ? '0 : (cur_step[gs] + STEP_W'(1));

        vstep_skip #(.STEP_W(STEP_W), .MASK_W(MASK_W)) u_skip (
            .from_i    (from_step[gs]),
            .vl_i      (vl_i),
            .mask_i    (side_mask[gs]),
            .zero_en_i (side_zen[gs]),
            .next_o    (next_step[gs])
        );

        vstep_offset #(.STEP_W(STEP_W), .SUB_W(SUB_W)) u_off (
            .step_i    (cur_step[gs]),
            .sub_i     (state_q.sub),
            .subvl_i   (subvl_i),
            .vl_i      (vl_i),
            .reverse_i (reverse_i),
            .offset_o  (side_off[gs])
        );

        assign sel_bit = side_mask[gs] >> cur_step[gs];
        assign side_zflag[gs] = side_zen[gs] && !state_q.done &&
                                ((cur_step[gs] >= STEP_W'(MASK_W)) || !sel_bit[0]);
    end

    logic exhausted;
    logic sub_last;

    always_comb begin
        exhausted = (next_step[SIDE_SRC] == vl_i) || (next_step[SIDE_DST] == vl_i);
        sub_last  = (state_q.sub == subvl_i);
        state_d   = state_q;
        if (start_i) begin
            state_d.src  = next_step[SIDE_SRC];
            state_d.dst  = next_step[SIDE_DST];
            state_d.sub  = '0;
            state_d.done = exhausted;
        end else if (advance_i && !state_q.done) begin
            if (!sub_last) begin
                state_d.sub = state_q.sub + SUB_W'(1);
            end else if (exhausted) begin
                state_d.done = 1'b1;
            end else begin
                state_d.src = next_step[SIDE_SRC];
                state_d.dst = next_step[SIDE_DST];
                state_d.sub = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{src: '0, dst: '0, sub: '0, done: 1'b1};
        end else begin
            state_q <= state_d;
        end
    end

    assign src_step_o   = state_q.src;
    assign dst_step_o   = state_q.dst;
    assign sub_step_o   = state_q.sub;
    assign done_o       = state_q.done;
    assign src_offset_o = side_off[SIDE_SRC];
    assign dst_offset_o = side_off[SIDE_DST];
    assign src_zero_o   = side_zflag[SIDE_SRC];
    assign dst_zero_o   = side_zflag[SIDE_DST];
endmodule

// File: rtl/vec_step_seq_chk.sv
`timescale 1ns/1ps
module vec_step_seq_chk
    import vstep_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              advance_i,
    input logic [SUB_W-1:0]  subvl_i,
    input logic [MASK_W-1:0] src_mask_i,
    input logic              src_zero_en_i,
    input logic [STEP_W-1:0] src_step_o,
    input logic [STEP_W-1:0] dst_step_o,
    input logic [SUB_W-1:0]  sub_step_o,
    input logic              src_zero_o,
    input logic              done_o
);
    logic [MASK_W-1:0] cur_src_bit;
    assign cur_src_bit = src_mask_i >> src_step_o;

    p_start_clears_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sub_step_o == '0));

    p_sub_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !start_i && !done_o && (sub_step_o != subvl_i)) |=>
        ((sub_step_o == $past(sub_step_o) + SUB_W'(1)) &&
         $stable(src_step_o) && $stable(dst_step_o)));

    p_sub_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !start_i && !done_o && (sub_step_o == subvl_i)) |=>
        ((sub_step_o == '0 && !done_o) || (done_o && $stable(sub_step_o))));

    p_no_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !src_zero_en_i) |->
        ((src_step_o < STEP_W'(MASK_W)) && cur_src_bit[0]));

    p_flag_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !src_zero_en_i |-> !src_zero_o);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=>
        (done_o && $stable(src_step_o) && $stable(dst_step_o) && $stable(sub_step_o)));
endmodule

bind vec_step_seq vec_step_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .advance_i     (advance_i),
    .subvl_i       (subvl_i),
    .src_mask_i    (src_mask_i),
    .src_zero_en_i (src_zero_en_i),
    .src_step_o    (src_step_o),
    .dst_step_o    (dst_step_o),
    .sub_step_o    (sub_step_o),
    .src_zero_o    (src_zero_o),
    .done_o        (done_o)
);

// File: tb/vec_step_seq_test.sv
`timescale 1ns/1ps
module vec_step_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        advance_i = 1'b0;
    logic [6:0]  vl_i = '0;
    logic [1:0]  subvl_i = '0;
    logic [63:0] src_mask_i = '0;
    logic [63:0] dst_mask_i = '0;
    logic        src_zero_en_i = 1'b0;
    logic        dst_zero_en_i = 1'b0;
    logic        reverse_i = 1'b0;
    logic [6:0]  src_step_o, dst_step_o, src_offset_o, dst_offset_o;
    logic [1:0]  sub_step_o;
    logic        src_zero_o, dst_zero_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vec_step_seq uut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [6:0] vl, input logic [1:0] svl,
                            input logic [63:0] sm, input logic [63:0] dm,
                            input logic sz, input logic dz, input logic rev);
        rst_n = 1'b0;
        vl_i = vl; subvl_i = svl; src_mask_i = sm; dst_mask_i = dm;
        src_zero_en_i = sz; dst_zero_en_i = dz; reverse_i = rev;
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic do_start();
        start_i = 1'b1; tick(); start_i = 1'b0;
    endtask

    task automatic do_adv();
        advance_i = 1'b1; tick(); advance_i = 1'b0;
    endtask

    task automatic expect_pos(input string req, input int s, input int d, input int sb,
                              input int dn);
        chk(req, "src_step", src_step_o, s);
        chk(req, "dst_step", dst_step_o, d);
        chk(req, "sub_step", sub_step_o, sb);
        chk(req, "done", done_o, dn);
    endtask

    task automatic t_reset();
        do_reset(7'd5, 2'd0, '1, '1, 1'b1, 1'b1, 1'b0);
        expect_pos("R1", 0, 0, 0, 1);
        chk("R1", "src_zero", src_zero_o, 0);
        chk("R1", "dst_zero", dst_zero_o, 0);
    endtask

    task automatic t_plain();
        do_reset(7'd3, 2'd1, '1, '1, 1'b0, 1'b0, 1'b0);
        do_start();
        expect_pos("R2", 0, 0, 0, 0);
        chk("R9", "src_off", src_offset_o, 0);
        do_adv();
        expect_pos("R4", 0, 0, 1, 0);
        chk("R9", "src_off", src_offset_o, 1);
        do_adv();
        expect_pos("R5", 1, 1, 0, 0);
        chk("R9", "dst_off", dst_offset_o, 2);
        do_adv();
        chk("R9", "src_off", src_offset_o, 3);
        do_adv();
        expect_pos("R5", 2, 2, 0, 0);
        chk("R9", "dst_off", dst_offset_o, 4);
        do_adv();
        chk("R9", "src_off", src_offset_o, 5);
        do_adv();
        expect_pos("R8", 2, 2, 1, 1);
        do_adv();
        expect_pos("R8", 2, 2, 1, 1);
    endtask

    task automatic t_skip();
        do_reset(7'd8, 2'd0, 64'b1010_0100, '1, 1'b0, 1'b0, 1'b0);
        do_start();
        expect_pos("R6", 2, 0, 0, 0);
        do_adv();
        expect_pos("R6", 5, 1, 0, 0);
        do_adv();
        expect_pos("R6", 7, 2, 0, 0);
        chk("R9", "src_off", src_offset_o, 7);
        do_adv();
        expect_pos("R8", 7, 2, 0, 1);
    endtask

    task automatic t_zero();
        do_reset(7'd4, 2'd0, 64'b0101, '1, 1'b1, 1'b0, 1'b0);
        do_start();
        chk("R7", "src_step", src_step_o, 0);
        chk("R7", "src_zero", src_zero_o, 0);
        do_adv();
        chk("R7", "src_step", src_step_o, 1);
        chk("R7", "src_zero", src_zero_o, 1);
        chk("R7", "dst_zero", dst_zero_o, 0);
        do_adv();
        chk("R7", "src_zero", src_zero_o, 0);
        do_adv();
        chk("R7", "src_step", src_step_o, 3);
        chk("R7", "src_zero", src_zero_o, 1);
        do_adv();
        chk("R7", "done", done_o, 1);
        chk("R7", "src_zero_done", src_zero_o, 0);
    endtask

    task automatic t_empty();
        do_reset(7'd0, 2'd2, '1, '1, 1'b0, 1'b0, 1'b0);
        do_start();
        chk("R3", "done_vl0", done_o, 1);
        do_adv();
        expect_pos("R3", 0, 0, 0, 1);
        do_reset(7'd4, 2'd0, 64'h0, '1, 1'b0, 1'b0, 1'b0);
        do_start();
        chk("R3", "done_nomask", done_o, 1);
    endtask

    task automatic t_reverse();
        do_reset(7'd3, 2'd1, '1, '1, 1'b0, 1'b0, 1'b1);
        do_start();
        chk("R10", "src_off", src_offset_o, 5);
        do_adv();
        chk("R10", "src_off", src_offset_o, 4);
        do_adv();
        chk("R10", "dst_off", dst_offset_o, 3);
        do_reset(7'd64, 2'd3, '1, '1, 1'b0, 1'b0, 1'b1);
        do_start();
        chk("R10", "wrap_off", src_offset_o, 127);
        do_adv();
        chk("R10", "wrap_off", src_offset_o, 126);
    endtask

    task automatic t_priority();
        do_reset(7'd3, 2'd1, '1, '1, 1'b0, 1'b0, 1'b0);
        do_start();
        do_adv();
        do_adv();
        expect_pos("R5", 1, 1, 0, 0);
        start_i = 1'b1; advance_i = 1'b1;
        tick();
        start_i = 1'b0; advance_i = 1'b0;
        expect_pos("R2", 0, 0, 0, 0);
    endtask

    task automatic t_dst_end();
        do_reset(7'd4, 2'd0, '1, 64'b0011, 1'b0, 1'b0, 1'b0);
        do_start();
        do_adv();
        expect_pos("R5", 1, 1, 0, 0);
        do_adv();
        expect_pos("R8", 1, 1, 0, 1);
    endtask

    task automatic t_wide_sub();
        do_reset(7'd2, 2'd3, '1, '1, 1'b0, 1'b0, 1'b0);
        do_start();
        for (int k = 0; k < 8; k++) begin
            chk("R9", "dst_off_seq", dst_offset_o, k);
            chk("R4", "sub_seq", sub_step_o, k % 4);
            do_adv();
        end
        chk("R8", "done", done_o, 1);
    endtask

    initial begin
        t_reset();
        t_plain();
        t_skip();
        t_zero();
        t_empty();
        t_reverse();
        t_priority();
        t_dst_end();
        t_wide_sub();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule